// File: doc/BRIEF.md
# Byte FIFO Pair with Programmable Ready Thresholds

This block buffers bytes in both directions between a register-mapped host port and a serial byte engine. Host writes go into a transmit queue that the engine drains one byte at a time. Bytes from the engine go into a receive queue that the host reads through a registered read-data output. Each side drives a ready flag. In queue mode that flag can be set to fire only when four entries are free (transmit) or waiting (receive), so a DMA engine can be triggered for a burst rather than for every byte.

A small mode controller has two states. In `MODE_HOLD` each side holds one byte at most and acts as a plain holding register. In `MODE_FIFO` each side holds up to `DEPTH` bytes. The controller leaves reset in `MODE_HOLD`. The `T_ENTER` transition, caused by `fifo_on_cmd` alone, moves it to `MODE_FIFO`. The `T_LEAVE` transition, caused by `fifo_off_cmd` alone, moves it back. Taking either transition empties both queues and clears both error flags. All other combinations take the `T_STAY` transition: no commands, both commands together, or a command that names the current mode. Software is expected to issue the enable command right after resetting the controller. Each side also has its own flush command.

Top module: `byte_fifo_pair`

## Requirements
- R1: After reset the block is in hold mode with:
  - both levels at 0 and both error flags at 0;
  - `rx_rdata` at 0;
  - `tx_ready` at 1 and `rx_ready` at 0.
- R2: Bytes leave each side in the order they were accepted. `eng_tx_data` shows the oldest transmit byte whenever `eng_tx_valid` is 1, and `eng_tx_valid` is 1 exactly when `tx_level` is non-zero.
- R3: In queue mode, `tx_ready` is 1 when free transmit entries (`DEPTH - tx_level`) are at least 4 with `tx_thr_four`=1, or at least 1 with `tx_thr_four`=0.
- R4: In queue mode, `rx_ready` is 1 when `rx_level` is at least 4 with `rx_thr_four`=1, or at least 1 with `rx_thr_four`=0.
- R5: In hold mode:
  - each side's capacity is one byte;
  - both threshold selects have no effect;
  - `tx_ready` = (`tx_level`==0) and `rx_ready` = (`rx_level`==1).
- R6: A host write while the transmit side is full is dropped. The level is unchanged and `tx_ovf` is set and stays set until a transmit flush or a mode transition.
- R7: An engine push while the receive side is full is dropped and sets the sticky `rx_ovf`. `eng_rx_space` is 1 exactly when the receive side is not full.
- R8: A host read from an empty receive side leaves `rx_level` unchanged and keeps `rx_rdata` at its previous value. A read from a non-empty side loads the oldest byte into `rx_rdata` one cycle later.
- R9: A flush empties only its own side and clears only its own error flag, one cycle later. A push, pop or write on the flushed side in the same cycle is ignored.
- R10: The mode transitions behave as named above. `fifo_mode` is 1 in `MODE_FIFO`.
- R11: A write (or push) and a pop (or read) on the same side in one cycle both take effect if the side is non-empty and not full, so the level does not change. If the side is full, the pop takes effect and the write is dropped with its error flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_on_cmd | input | 1 | Pulse: enter queue mode |
| fifo_off_cmd | input | 1 | Pulse: return to hold mode |
| tx_thr_four | input | 1 | Transmit ready threshold: 0 = one entry, 1 = four entries |
| rx_thr_four | input | 1 | Receive ready threshold: 0 = one entry, 1 = four entries |
| tx_flush | input | 1 | Pulse: empty the transmit side |
| rx_flush | input | 1 | Pulse: empty the receive side |
| tx_wr | input | 1 | Host byte write strobe |
| tx_wdata | input | 8 | Host write byte |
| eng_tx_pop | input | 1 | Engine takes the oldest transmit byte |
| eng_tx_data | output | 8 | Oldest transmit byte |
| eng_tx_valid | output | 1 | Transmit side holds at least one byte |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_rx_space | output | 1 | Receive side can accept a byte |
| rx_rd | input | 1 | Host byte read strobe |
| rx_rdata | output | 8 | Last byte read by the host |
| tx_ready | output | 1 | Transmit request flag (threshold applied) |
| rx_ready | output | 1 | Receive request flag (threshold applied) |
| tx_level | output | $clog2(DEPTH+1) | Transmit occupancy |
| rx_level | output | $clog2(DEPTH+1) | Receive occupancy |
| tx_ovf | output | 1 | Sticky: transmit write dropped |
| rx_ovf | output | 1 | Sticky: receive push dropped |
| fifo_mode | output | 1 | 1 in queue mode |

## Verification
On each side, the filling action and the draining action can land in the same cycle, and so can a flush and a write. The sharpest case is a host write together with an engine pop while the transmit side is exactly full. The write must be dropped and flagged while the pop still advances. A mirror case is a receive flush together with an engine push, where the push must vanish. Both are driven on purpose, and they also arise during a long stretch of random strobes. Each cycle, a queue-based model predicts level, head byte, flags and read data, and the bench compares every output against it.

// File: rtl/byte_fifo_pkg.sv
package byte_fifo_pkg;
    typedef enum logic {
        MODE_HOLD = 1'b0,
        MODE_FIFO = 1'b1
    } fifo_mode_e;

    localparam int unsigned BURST_ENTRIES = 4;
endpackage

// File: rtl/bfq_mode_ctl.sv
module bfq_mode_ctl
    import byte_fifo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic on_cmd,
    input  logic off_cmd,
    output logic queue_mode,
    output logic mode_switch
);
    fifo_mode_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_HOLD;
        else        state_q <= state_d;
    end

    // next state: T_ENTER, T_LEAVE, otherwise T_STAY
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_HOLD: if (on_cmd && !off_cmd) state_d = MODE_FIFO;
            MODE_FIFO: if (off_cmd && !on_cmd) state_d = MODE_HOLD;
            default:   state_d = MODE_HOLD;
        endcase
    end

    // outputs
    always_comb begin
        queue_mode  = (state_q == MODE_FIFO);
        mode_switch = (state_d != state_q);
    end
endmodule

// File: rtl/bfq_ring.sv
module bfq_ring
    import byte_fifo_pkg::*;
#(
    parameter int unsigned DEPTH   = 16,
    parameter bit          FREE_RDY = 1'b1,
    localparam int unsigned LVL_W  = $clog2(DEPTH + 1),
    localparam int unsigned PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             queue_mode,
    input  logic             thr_four,
    input  logic             push,
    input  logic [7:0]       push_data,
    input  logic             pop,
    output logic [7:0]       head,
    output logic [LVL_W-1:0] level,
    output logic             full,
    output logic             ready,
    output logic             ovf
);
    logic [7:0]       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [LVL_W-1:0] cap, thr, free_n;
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        cap     = queue_mode ? LVL_W'(DEPTH) : LVL_W'(1);
        thr     = (queue_mode && thr_four) ? LVL_W'(BURST_ENTRIES) : LVL_W'(1);
        full    = (level >= cap);
        free_n  = cap - level;
        do_push = push && !full && !clear;
        do_pop  = pop && (level != '0) && !clear;
        head    = mem[rd_ptr];
    end

    generate
        if (FREE_RDY) begin : g_free
            assign ready = (free_n >= thr);
        end else begin : g_fill
            assign ready = (level >= thr);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
            ovf    <= 1'b0;
        end else if (clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
            ovf    <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            if (do_push && !do_pop)      level <= level + 1'b1;
            else if (do_pop && !do_push) level <= level - 1'b1;
            if (push && full) ovf <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end
endmodule

// File: rtl/byte_fifo_pair.sv
module byte_fifo_pair
    import byte_fifo_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_on_cmd,
    input  logic             fifo_off_cmd,
    input  logic             tx_thr_four,
    input  logic             rx_thr_four,
    input  logic             tx_flush,
    input  logic             rx_flush,
    input  logic             tx_wr,
    input  logic [7:0]       tx_wdata,
    input  logic             eng_tx_pop,
    output logic [7:0]       eng_tx_data,
    output logic             eng_tx_valid,
    input  logic             eng_rx_push,
    input  logic [7:0]       eng_rx_data,
    output logic             eng_rx_space,
    input  logic             rx_rd,
    output logic [7:0]       rx_rdata,
    output logic             tx_ready,
    output logic             rx_ready,
    output logic [LVL_W-1:0] tx_level,
    output logic [LVL_W-1:0] rx_level,
    output logic             tx_ovf,
    output logic             rx_ovf,
    output logic             fifo_mode
);
    logic       mode_switch;
    logic       tx_full, rx_full;
    logic [7:0] rx_head;

    bfq_mode_ctl u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .on_cmd     (fifo_on_cmd),
        .off_cmd    (fifo_off_cmd),
        .queue_mode (fifo_mode),
        .mode_switch(mode_switch)
    );

    bfq_ring #(.DEPTH(DEPTH), .FREE_RDY(1'b1)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (tx_flush || mode_switch),
        .queue_mode(fifo_mode),
        .thr_four  (tx_thr_four),
        .push      (tx_wr),
        .push_data (tx_wdata),
        .pop       (eng_tx_pop),
        .head      (eng_tx_data),
        .level     (tx_level),
        .full      (tx_full),
        .ready     (tx_ready),
        .ovf       (tx_ovf)
    );

    bfq_ring #(.DEPTH(DEPTH), .FREE_RDY(1'b0)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (rx_flush || mode_switch),
        .queue_mode(fifo_mode),
        .thr_four  (rx_thr_four),
        .push      (eng_rx_push),
        .push_data (eng_rx_data),
        .pop       (rx_rd),
        .head      (rx_head),
        .level     (rx_level),
        .full      (rx_full),
        .ready     (rx_ready),
        .ovf       (rx_ovf)
    );

    assign eng_tx_valid = (tx_level != '0);
    assign eng_rx_space = !rx_full;

    // host read data register: loads only on a read that takes a byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_rdata <= '0;
        else if (rx_rd && (rx_level != '0) && !rx_flush && !mode_switch)
            rx_rdata <= rx_head;
    end
endmodule

// File: rtl/bfq_checker.sv
module bfq_checker #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fifo_on_cmd,
    input logic             fifo_off_cmd,
    input logic             tx_flush,
    input logic             rx_flush,
    input logic             rx_rd,
    input logic [7:0]       rx_rdata,
    input logic             rx_ready,
    input logic [LVL_W-1:0] tx_level,
    input logic [LVL_W-1:0] rx_level,
    input logic             tx_ovf,
    input logic             fifo_mode
);
    // R6
    tx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_level <= LVL_W'(DEPTH));
    // R6
    tx_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ovf && !tx_flush && !fifo_on_cmd && !fifo_off_cmd) |=> tx_ovf);
    // R9
    tx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_flush |=> (tx_level == '0));
    // R9
    rx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush |=> (rx_level == '0));
    // R5
    hold_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_mode |-> (tx_level <= 1 && rx_level <= 1));
    // R8
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd && rx_level == '0) |=> $stable(rx_rdata));
    // R10
    enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_on_cmd && !fifo_off_cmd && !fifo_mode) |=>
            (fifo_mode && tx_level == '0 && rx_level == '0));
    // R4
    rx_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |-> (rx_level != '0));
endmodule

bind byte_fifo_pair bfq_checker #(.DEPTH(DEPTH)) u_bfq_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fifo_on_cmd (fifo_on_cmd),
    .fifo_off_cmd(fifo_off_cmd),
    .tx_flush    (tx_flush),
    .rx_flush    (rx_flush),
    .rx_rd       (rx_rd),
    .rx_rdata    (rx_rdata),
    .rx_ready    (rx_ready),
    .tx_level    (tx_level),
    .rx_level    (rx_level),
    .tx_ovf      (tx_ovf),
    .fifo_mode   (fifo_mode)
);

// File: tb/byte_fifo_pair_tb_top.sv
module byte_fifo_pair_tb_top;
    localparam int DEPTH = 16;
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fifo_on_cmd = 0, fifo_off_cmd = 0, tx_thr_four = 0, rx_thr_four = 0;
    logic tx_flush = 0, rx_flush = 0, tx_wr = 0, eng_tx_pop = 0, eng_rx_push = 0, rx_rd = 0;
    logic [7:0] tx_wdata = 0, eng_rx_data = 0;
    logic [7:0] eng_tx_data, rx_rdata;
    logic eng_tx_valid, eng_rx_space, tx_ready, rx_ready, tx_ovf, rx_ovf, fifo_mode;
    logic [LVL_W-1:0] tx_level, rx_level;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    byte_fifo_pair #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .fifo_on_cmd(fifo_on_cmd), .fifo_off_cmd(fifo_off_cmd),
        .tx_thr_four(tx_thr_four), .rx_thr_four(rx_thr_four), .tx_flush(tx_flush),
        .rx_flush(rx_flush), .tx_wr(tx_wr), .tx_wdata(tx_wdata), .eng_tx_pop(eng_tx_pop),
        .eng_tx_data(eng_tx_data), .eng_tx_valid(eng_tx_valid), .eng_rx_push(eng_rx_push),
        .eng_rx_data(eng_rx_data), .eng_rx_space(eng_rx_space), .rx_rd(rx_rd),
        .rx_rdata(rx_rdata), .tx_ready(tx_ready), .rx_ready(rx_ready), .tx_level(tx_level),
        .rx_level(rx_level), .tx_ovf(tx_ovf), .rx_ovf(rx_ovf), .fifo_mode(fifo_mode)
    );

    // behavioural reference model
    logic [7:0] m_txq[$];
    logic [7:0] m_rxq[$];
    bit m_mode = 0, m_txo = 0, m_rxo = 0;
    logic [7:0] m_rdata = 0;

    function automatic int cap_of();
        return m_mode ? DEPTH : 1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_txq.delete(); m_rxq.delete();
            m_mode = 0; m_txo = 0; m_rxo = 0; m_rdata = 0;
        end else if ((fifo_on_cmd && !fifo_off_cmd && !m_mode) ||
                     (fifo_off_cmd && !fifo_on_cmd && m_mode)) begin
            m_mode = !m_mode;
            m_txq.delete(); m_rxq.delete();
            m_txo = 0; m_rxo = 0;
        end else begin
            if (tx_flush) begin
                m_txq.delete(); m_txo = 0;
            end else begin
                bit was_full;
                was_full = (m_txq.size() >= cap_of());
                if (eng_tx_pop && m_txq.size() > 0) void'(m_txq.pop_front());
                if (tx_wr) begin
                    if (was_full) m_txo = 1;
                    else m_txq.push_back(tx_wdata);
                end
            end
            if (rx_flush) begin
                m_rxq.delete(); m_rxo = 0;
            end else begin
                bit was_full;
                was_full = (m_rxq.size() >= cap_of());
                if (rx_rd && m_rxq.size() > 0) m_rdata = m_rxq.pop_front();
                if (eng_rx_push) begin
                    if (was_full) m_rxo = 1;
                    else m_rxq.push_back(eng_rx_data);
                end
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic compare_all();
        int thr_t, thr_r, free_t;
        thr_t = (m_mode && tx_thr_four) ? 4 : 1;
        thr_r = (m_mode && rx_thr_four) ? 4 : 1;
        free_t = cap_of() - m_txq.size();
        chk("R2 tx_level", int'(tx_level), m_txq.size());
        chk("R2 rx_level", int'(rx_level), m_rxq.size());
        chk("R2 eng_tx_valid", int'(eng_tx_valid), int'(m_txq.size() > 0));
        if (m_txq.size() > 0) chk("R2 eng_tx_data", int'(eng_tx_data), int'(m_txq[0]));
        chk("R3 tx_ready", int'(tx_ready), int'(free_t >= thr_t));
        chk("R4 rx_ready", int'(rx_ready), int'(m_rxq.size() >= thr_r));
        chk("R6 tx_ovf", int'(tx_ovf), int'(m_txo));
        chk("R7 rx_ovf", int'(rx_ovf), int'(m_rxo));
        chk("R7 eng_rx_space", int'(eng_rx_space), int'(m_rxq.size() < cap_of()));
        chk("R8 rx_rdata", int'(rx_rdata), int'(m_rdata));
        chk("R10 fifo_mode", int'(fifo_mode), int'(m_mode));
    endtask

    // compare current outputs, advance one clock, return all strobes to idle
    task automatic step();
        #1;
        compare_all();
        @(posedge clk);
        @(negedge clk);
        fifo_on_cmd = 0; fifo_off_cmd = 0; tx_flush = 0; rx_flush = 0;
        tx_wr = 0; eng_tx_pop = 0; eng_rx_push = 0; rx_rd = 0;
    endtask

    task automatic summary_and_end();
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            summary_and_end();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state
        chk("R1 tx_level", int'(tx_level), 0);
        chk("R1 rx_level", int'(rx_level), 0);
        chk("R1 tx_ready", int'(tx_ready), 1);
        chk("R1 rx_ready", int'(rx_ready), 0);
        chk("R1 fifo_mode", int'(fifo_mode), 0);
        chk("R1 flags", int'(tx_ovf) + int'(rx_ovf), 0);
        chk("R1 rx_rdata", int'(rx_rdata), 0);
        @(negedge clk);

        // R5 hold mode: one entry, threshold select ignored
        tx_thr_four = 1; rx_thr_four = 1;
        tx_wr = 1; tx_wdata = 8'hA1; step();
        chk("R5 hold tx_ready", int'(tx_ready), 0);
        tx_wr = 1; tx_wdata = 8'hA2; step();
        chk("R6 hold drop", int'(tx_ovf), 1);
        eng_rx_push = 1; eng_rx_data = 8'h5C; step();
        chk("R5 hold rx_ready", int'(rx_ready), 1);
        rx_rd = 1; step();
        chk("R8 read byte", int'(rx_rdata), 8'h5C);
        rx_rd = 1; step();
        chk("R8 empty read keeps", int'(rx_rdata), 8'h5C);
        // R10 command naming current mode: no flush
        fifo_off_cmd = 1; step();
        chk("R10 same-state cmd", int'(tx_level), 1);

        // R10 both commands together: no change
        fifo_on_cmd = 1; fifo_off_cmd = 1; step();
        chk("R10 both cmds", int'(fifo_mode), 0);
        fifo_on_cmd = 1; step();
        chk("R10 enter", int'(fifo_mode), 1);
        chk("R10 enter clears", int'(tx_level) + int'(tx_ovf), 0);

        // R3 fill transmit side to full with four-entry threshold
        for (int i = 0; i < DEPTH; i++) begin
            tx_wr = 1; tx_wdata = 8'(8'h10 + i); step();
            if (i == DEPTH - 4) chk("R3 free=3", int'(tx_ready), 0);
        end
        // R11 write + pop at full: pop advances, write dropped
        tx_wr = 1; tx_wdata = 8'hEE; eng_tx_pop = 1; step();
        chk("R11 level", int'(tx_level), DEPTH - 1);
        chk("R11 ovf", int'(tx_ovf), 1);
        chk("R11 head", int'(eng_tx_data), 8'h11);
        // R11 non-full write + pop: level unchanged
        tx_wr = 1; tx_wdata = 8'h77; eng_tx_pop = 1; step();
        chk("R11 steady level", int'(tx_level), DEPTH - 1);
        for (int i = 0; i < DEPTH + 2; i++) begin
            eng_tx_pop = 1; step();
        end
        tx_flush = 1; step();
        chk("R9 tx flush clears flag", int'(tx_ovf), 0);

        // R4 receive threshold
        for (int i = 0; i < 4; i++) begin
            eng_rx_push = 1; eng_rx_data = 8'(8'h40 + i); step();
            if (i == 2) chk("R4 three entries", int'(rx_ready), 0);
        end
        chk("R4 four entries", int'(rx_ready), 1);
        // R9 rx flush with concurrent push, tx side untouched
        tx_wr = 1; tx_wdata = 8'h99; step();
        rx_flush = 1; eng_rx_push = 1; eng_rx_data = 8'h12; step();
        chk("R9 rx flushed", int'(rx_level), 0);
        chk("R9 tx kept", int'(tx_level), 1);
        // R7 overfill receive side
        for (int i = 0; i < DEPTH + 1; i++) begin
            eng_rx_push = 1; eng_rx_data = 8'(i); step();
        end
        chk("R7 rx_ovf", int'(rx_ovf), 1);

        // mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            tx_thr_four = ($urandom_range(0, 3) == 0);
            rx_thr_four = ($urandom_range(0, 1) == 0);
            tx_wr = ($urandom_range(0, 1) == 0); tx_wdata = 8'($urandom);
            eng_tx_pop = ($urandom_range(0, 2) == 0);
            eng_rx_push = ($urandom_range(0, 1) == 0); eng_rx_data = 8'($urandom);
            rx_rd = ($urandom_range(0, 2) == 0);
            tx_flush = ($urandom_range(0, 60) == 0);
            rx_flush = ($urandom_range(0, 60) == 0);
            fifo_on_cmd = ($urandom_range(0, 200) == 0);
            fifo_off_cmd = ($urandom_range(0, 250) == 0);
            step();
        end

        // R10 leave queue mode
        fifo_on_cmd = 1; step();
        tx_wr = 1; tx_wdata = 8'h33; step();
        fifo_off_cmd = 1; step();
        chk("R10 leave", int'(fifo_mode), 0);
        chk("R10 leave clears", int'(tx_level), 0);
        step();
        summary_and_end();
    end
endmodule